// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block keeps the fault registers that a memory management unit fills when an access cannot complete. A translation fault or a misaligned access presents a one-cycle strobe together with the access details. On that strobe the block builds a status word and stores it in the status register. The word is built from the translation regime the access used, the kind of access and the processor privilege at that moment. In the same cycle the block stores the faulting virtual address in the address register. It also stores a tag word in the tag register: the upper address bits with the context number placed in the low bits.

Software reads the registers through a small port. The port has a select, a read strobe, a write strobe and write data, and the selected register appears combinationally on `rd_data`. A small controller follows whether the stored fault has been seen. It has three states:

- `ST_EMPTY`: no valid fault is held.
- `ST_LOADED`: a fault is held and has not been read.
- `ST_READ`: the status register has been read since the last capture.

Its transitions are:

- capture, from any state, goes to `ST_LOADED`.
- a status read goes from `ST_LOADED` to `ST_READ`.
- a write of zero to the status register goes from `ST_READ` to `ST_EMPTY` and clears the valid bit.

A fault that arrives while the valid bit is still set marks overflow in the new word.

Top module: `fsr_recorder`

## Requirements
- R1: After reset the status, address and tag registers read as zero, and select code 3 always reads zero.
- R2: Every captured status word has bit 0 (valid) set and bit 7 clear.
- R3: Bits 3:2 hold the context class. Regime input code 0 (untranslated) gives 0. Codes 1 and 2 (user or kernel primary) give 1. Codes 3 and 4 (user or kernel secondary) give 2. Code 5 (nucleus) and the unused codes 6 and 7 give 3.
- R4: Access code 1 (store) sets bit 4 and access code 3 (no-fault load) sets bit 5. Codes 0 (load) and 2 (fetch) set neither bit.
- R5: Bit 6 copies the privilege input at the time of the fault.
- R6: Bit 1 (overflow) is set in the new word exactly when the stored valid bit was set at the time of the capture.
- R7: On a capture the address register (select 1) takes the full virtual address. The tag register (select 2) takes the address with its low CTX_W bits replaced by the context number.
- R8: The alignment-fault strobe captures status, address and tag exactly as the translation-fault strobe does.
- R9: A read of the status register (select 0) followed by a write of zero to it clears the valid bit, so the next fault does not flag overflow.
- R10: A write of zero to the status register without a status read since the last capture is ignored, and a non-zero write to it is always ignored.
- R11: A fault in the same cycle as a clearing write takes precedence: the new word is captured and valid stays set.
- R12: Writes to the address and tag registers have no effect, and these registers change only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_fault | input | 1 | Translation fault strobe |
| align_fault | input | 1 | Misaligned access fault strobe |
| fault_regime | input | 3 | Translation regime of the access (R3 codes) |
| fault_access | input | 2 | Access kind (R4 codes) |
| fault_priv | input | 1 | Processor privileged at fault time |
| fault_va | input | VA_W | Faulting virtual address |
| fault_ctx | input | CTX_W | Context number of the access |
| reg_sel | input | 2 | Register select: 0 status, 1 address, 2 tag |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | VA_W | Write data |
| rd_data | output | VA_W | Selected register contents |

## Verification
A wrong controller state shows first as a wrong overflow bit, one capture later. It can also show as a valid bit that a clearing write fails to drop, or one that drops without a prior read; that is visible in the next cycle's status read. A wrong field mapping appears in the status read right after the capture cycle. Because every read is combinational, comparing `rd_data` on every clock against a behavioural model exposes any divergence within one cycle of the select pointing at the corrupted register.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int STAT_W   = 8;
    localparam int SB_VALID = 0;
    localparam int SB_OVF   = 1;
    localparam int SB_CC    = 2;
    localparam int SB_WRITE = 4;
    localparam int SB_NF    = 5;
    localparam int SB_PRIV  = 6;

    localparam logic [2:0] RG_PHYS     = 3'd0;
    localparam logic [2:0] RG_USER_PRI = 3'd1;
    localparam logic [2:0] RG_KERN_PRI = 3'd2;
    localparam logic [2:0] RG_USER_SEC = 3'd3;
    localparam logic [2:0] RG_KERN_SEC = 3'd4;

    localparam logic [1:0] AC_STORE  = 2'd1;
    localparam logic [1:0] AC_NFLOAD = 2'd3;

    localparam logic [1:0] CC_NONE = 2'd0;
    localparam logic [1:0] CC_PRI  = 2'd1;
    localparam logic [1:0] CC_SEC  = 2'd2;
    localparam logic [1:0] CC_NUC  = 2'd3;

    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_TAG  = 2'd2;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_LOADED = 2'd1,
        ST_READ   = 2'd2
    } st_e;
endpackage

// File: rtl/fsr_word_build.sv
module fsr_word_build
    import fsr_pkg::*;
(
    input  logic [2:0]        regime,
    input  logic [1:0]        access,
    input  logic              priv,
    input  logic              prev_valid,
    output logic [STAT_W-1:0] word
);
    logic [1:0] cls;

    always_comb begin
        unique case (regime)
            RG_PHYS:                  cls = CC_NONE;
            RG_USER_PRI, RG_KERN_PRI: cls = CC_PRI;
            RG_USER_SEC, RG_KERN_SEC: cls = CC_SEC;
            default:                  cls = CC_NUC;
        endcase
    end

    always_comb begin
        word                    = '0;
        word[SB_VALID]          = 1'b1;
        word[SB_OVF]            = prev_valid;
        word[SB_CC +: 2]        = cls;
        word[SB_WRITE]          = (access == AC_STORE);
        word[SB_NF]             = (access == AC_NFLOAD);
        word[SB_PRIV]           = priv;
    end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic rd_stat,
    input  logic wr_zero,
    output logic clr_valid
);
    st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d = ST_LOADED;
        end else begin
            unique case (st_q)
                ST_EMPTY:  st_d = ST_EMPTY;
                ST_LOADED: if (rd_stat) st_d = ST_READ;
                ST_READ:   if (wr_zero) st_d = ST_EMPTY;
                default:   st_d = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        clr_valid = (st_q == ST_READ) && wr_zero && !capture;
    end
endmodule

// File: rtl/fsr_recorder.sv
module fsr_recorder
    import fsr_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int CTX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlat_fault,
    input  logic             align_fault,
    input  logic [2:0]       fault_regime,
    input  logic [1:0]       fault_access,
    input  logic             fault_priv,
    input  logic [VA_W-1:0]  fault_va,
    input  logic [CTX_W-1:0] fault_ctx,
    input  logic [1:0]       reg_sel,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [VA_W-1:0]  reg_wdata,
    output logic [VA_W-1:0]  rd_data
);
    localparam int PAD_W = VA_W - STAT_W;

    logic              capture;
    logic              rd_stat;
    logic              wr_zero;
    logic              clr_valid;
    logic [STAT_W-1:0] new_word;
    logic [STAT_W-1:0] stat_q;
    logic [VA_W-1:0]   addr_q;
    logic [VA_W-1:0]   tag_q;

    assign capture = xlat_fault | align_fault;
    assign rd_stat = reg_rd && (reg_sel == SEL_STAT);
    assign wr_zero = reg_wr && (reg_sel == SEL_STAT) && (reg_wdata == '0);

    fsr_word_build u_build (
        .regime     (fault_regime),
        .access     (fault_access),
        .priv       (fault_priv),
        .prev_valid (stat_q[SB_VALID]),
        .word       (new_word)
    );

    fsr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .rd_stat   (rd_stat),
        .wr_zero   (wr_zero),
        .clr_valid (clr_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            addr_q <= '0;
            tag_q  <= '0;
        end else if (capture) begin
            stat_q <= new_word;
            addr_q <= fault_va;
            tag_q  <= {fault_va[VA_W-1:CTX_W], fault_ctx};
        end else if (clr_valid) begin
            stat_q[SB_VALID] <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_STAT: rd_data = {{PAD_W{1'b0}}, stat_q};
            SEL_ADDR: rd_data = addr_q;
            SEL_TAG:  rd_data = tag_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/fsr_recorder_chk.sv
module fsr_recorder_chk #(
    parameter int VA_W  = 64,
    parameter int CTX_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xlat_fault,
    input logic             align_fault,
    input logic [2:0]       fault_regime,
    input logic             fault_priv,
    input logic [VA_W-1:0]  fault_va,
    input logic [CTX_W-1:0] fault_ctx,
    input logic [7:0]       stat_q,
    input logic [VA_W-1:0]  addr_q,
    input logic [VA_W-1:0]  tag_q
);
    logic cap;
    assign cap = xlat_fault | align_fault;

    p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> stat_q[0] && !stat_q[7]);
    p_phys_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap && fault_regime == 3'd0 |=> stat_q[3:2] == 2'd0);
    p_access_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !(stat_q[4] && stat_q[5]));
    p_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> stat_q[6] == $past(fault_priv));
    p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap && stat_q[0] |=> stat_q[1]);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap && !stat_q[0] |=> !stat_q[1]);
    p_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> addr_q == $past(fault_va));
    p_tag_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> tag_q[CTX_W-1:0] == $past(fault_ctx));
    p_tag_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> tag_q[VA_W-1:CTX_W] == $past(fault_va[VA_W-1:CTX_W]));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(addr_q) && $stable(tag_q));
endmodule

bind fsr_recorder fsr_recorder_chk #(.VA_W(VA_W), .CTX_W(CTX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .xlat_fault   (xlat_fault),
    .align_fault  (align_fault),
    .fault_regime (fault_regime),
    .fault_priv   (fault_priv),
    .fault_va     (fault_va),
    .fault_ctx    (fault_ctx),
    .stat_q       (stat_q),
    .addr_q       (addr_q),
    .tag_q        (tag_q)
);

// File: tb/fsr_recorder_tb_top.sv
module fsr_recorder_tb_top;
    localparam int CLK_P = 10;
    localparam int VA_W  = 64;
    localparam int CTX_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xlat_fault = 1'b0, align_fault = 1'b0;
    logic [2:0]       fault_regime = '0;
    logic [1:0]       fault_access = '0;
    logic             fault_priv = 1'b0;
    logic [VA_W-1:0]  fault_va = '0;
    logic [CTX_W-1:0] fault_ctx = '0;
    logic [1:0]       reg_sel = '0;
    logic             reg_rd = 1'b0, reg_wr = 1'b0;
    logic [VA_W-1:0]  reg_wdata = '0;
    logic [VA_W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [VA_W-1:0] m_stat = '0, m_addr = '0, m_tag = '0;
    bit m_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    fsr_recorder #(.VA_W(VA_W), .CTX_W(CTX_W)) dut_i (.*);

    function automatic logic [VA_W-1:0] exp_word(input logic [2:0] rg, input logic [1:0] ac,
                                                 input bit pv, input bit prev);
        logic [VA_W-1:0] w = '0;
        int cls;
        if (rg == 0) cls = 0;
        else if (rg <= 2) cls = 1;
        else if (rg <= 4) cls = 2;
        else cls = 3;
        w[0] = 1'b1;          // R2
        w[1] = prev;          // R6
        w[3:2] = cls[1:0];    // R3
        w[4] = (ac == 2'd1);  // R4
        w[5] = (ac == 2'd3);  // R4
        w[6] = pv;            // R5
        return w;
    endfunction

    function automatic logic [VA_W-1:0] exp_sel(input logic [1:0] s);
        case (s)
            2'd0: return m_stat;
            2'd1: return m_addr;
            2'd2: return m_tag;
            default: return '0;
        endcase
    endfunction

    // one clock: drive, compare current registers, clock, update model
    task automatic step(input string req, input bit xf, input bit af, input logic [2:0] rg,
                        input logic [1:0] ac, input bit pv, input logic [VA_W-1:0] va,
                        input logic [CTX_W-1:0] cx, input bit re, input bit we,
                        input logic [1:0] sel, input logic [VA_W-1:0] wd);
        logic [VA_W-1:0] e;
        xlat_fault = xf; align_fault = af; fault_regime = rg; fault_access = ac;
        fault_priv = pv; fault_va = va; fault_ctx = cx;
        reg_rd = re; reg_wr = we; reg_sel = sel; reg_wdata = wd;
        #1;
        e = exp_sel(sel);
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, rd_data, e);
        end
        @(posedge clk);
        if (xf || af) begin
            m_stat = exp_word(rg, ac, pv, m_stat[0]);
            m_addr = va;
            m_tag  = {va[VA_W-1:CTX_W], cx};
            m_seen = 0;
        end else if (we && sel == 2'd0 && wd == '0 && m_seen) begin
            m_stat[0] = 1'b0;
            m_seen = 0;
        end else if (re && sel == 2'd0 && m_stat[0]) begin
            m_seen = 1;
        end
        @(negedge clk);
    endtask

    task automatic peek(input string req, input logic [1:0] sel);
        step(req, 0, 0, 0, 0, 0, '0, '0, 0, 0, sel, '0);
    endtask

    task automatic fault(input string req, input bit align, input logic [2:0] rg,
                         input logic [1:0] ac, input bit pv, input logic [VA_W-1:0] va,
                         input logic [CTX_W-1:0] cx);
        step(req, !align, align, rg, ac, pv, va, cx, 0, 0, 2'd0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        peek("R1", 2'd0); peek("R1", 2'd1); peek("R1", 2'd2); peek("R1", 2'd3);
        // R2 R3 R7 first capture, user primary load
        fault("R2", 0, 3'd1, 2'd0, 0, 64'h1234_5678_9ABC_DEF0, 13'h0ABC);
        peek("R2", 2'd0); peek("R7", 2'd1); peek("R7", 2'd2);
        // R6 second fault before any read
        fault("R6", 0, 3'd4, 2'd1, 1, 64'hFFFF_0000_1111_2222, 13'h1FFF);
        peek("R6", 2'd0); peek("R7", 2'd2);
        // R9 read then clear, next fault no overflow
        step("R9", 0, 0, 0, 0, 0, '0, '0, 1, 0, 2'd0, '0);
        step("R9", 0, 0, 0, 0, 0, '0, '0, 0, 1, 2'd0, '0);
        peek("R9", 2'd0);
        fault("R9", 0, 3'd0, 2'd2, 0, 64'h0000_0000_0000_1FFF, 13'h0001);
        peek("R9", 2'd0);
        // R10 clear without read ignored; non-zero write ignored
        step("R10", 0, 0, 0, 0, 0, '0, '0, 0, 1, 2'd0, '0);
        peek("R10", 2'd0);
        step("R10", 0, 0, 0, 0, 0, '0, '0, 0, 1, 2'd0, 64'h1);
        peek("R10", 2'd0);
        // R12 writes to address and tag ignored
        step("R12", 0, 0, 0, 0, 0, '0, '0, 0, 1, 2'd1, '0);
        step("R12", 0, 0, 0, 0, 0, '0, '0, 0, 1, 2'd2, 64'hDEAD);
        peek("R12", 2'd1); peek("R12", 2'd2);
        // R8 alignment strobe, nucleus, no-fault load
        fault("R8", 1, 3'd5, 2'd3, 1, 64'hA5A5_A5A5_0000_4000, 13'h0123);
        peek("R8", 2'd0); peek("R8", 2'd1); peek("R8", 2'd2);
        // R11 fault in same cycle as clearing write
        step("R11", 0, 0, 0, 0, 0, '0, '0, 1, 0, 2'd0, '0);
        step("R11", 1, 0, 3'd2, 2'd0, 0, 64'h42, 13'h7, 0, 1, 2'd0, '0);
        peek("R11", 2'd0);
        step("R11", 0, 0, 0, 0, 0, '0, '0, 0, 1, 2'd0, '0);
        peek("R11", 2'd0);
        // R3 R4 R5 sweep of regime, access and privilege
        for (int r = 0; r < 8; r++) begin
            for (int a = 0; a < 4; a++) begin
                fault("R3", (a == 2), r[2:0], a[1:0], r[0], 64'(r * 4096 + a), 13'(r + a));
                peek("R4", 2'd0);
                if (a == 1) begin
                    step("R5", 0, 0, 0, 0, 0, '0, '0, 1, 0, 2'd0, '0);
                    step("R9", 0, 0, 0, 0, 0, '0, '0, 0, 1, 2'd0, '0);
                end
            end
        end
        peek("R7", 2'd2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule